// File: doc/BRIEF.md
# Accumulator Shift and Carry Unit

This block applies one rotate or shift step to an 8-bit accumulator value and produces the carry flag that goes with it. The accumulator value and the current carry arrive on inputs. A 3-bit operation code picks one of six moves: plain rotate left or right, rotate through carry left or right, and arithmetic shift left or right. When the operation enable is high, the result and the new carry are captured on the clock edge. At all other times the registered outputs hold their values.

The unit also supplies the carry-in for the adder's add and subtract variants. A small selector passes on the incoming carry, a forced 0 or a forced 1. The adder, the zero and sign flags, and bus control are handled elsewhere. Inside the block, a control decoder turns the operation code into a direction strobe and a fill-source choice. The datapath then routes the two end bits and the carry through two multiplexers: one picks the bit that leaves the word, the other picks the bit that fills the vacated position.

Top module: `acc_shift_unit`

## Requirements
- R1: While `rstN` is low, `accOut` and `carryOut` are 0 at every clock edge, whatever the other inputs are.
- R2: Rotate left (opCode 3'b000, opEn high): `accOut` becomes {accIn[6:0], accIn[7]}, and `carryOut` becomes accIn[7] after the clock edge.
- R3: Rotate right (opCode 3'b001): `accOut` becomes {accIn[0], accIn[7:1]}, and `carryOut` becomes accIn[0].
- R4: Rotate left through carry (opCode 3'b010): `accOut` becomes {accIn[6:0], carryIn}, and `carryOut` becomes accIn[7].
- R5: Rotate right through carry (opCode 3'b011): `accOut` becomes {carryIn, accIn[7:1]}, and `carryOut` becomes accIn[0].
- R6: Arithmetic shift left (opCode 3'b100): `accOut` becomes {accIn[6:0], 1'b0}, and `carryOut` becomes accIn[7].
- R7: Arithmetic shift right (opCode 3'b101): `accOut` becomes {accIn[7], accIn[7:1]}, so bit 7 is kept, and `carryOut` becomes accIn[0].
- R8: With opEn high and opCode 3'b110 or 3'b111, `accOut` and `carryOut` keep their previous values.
- R9: With opEn low, `accOut` and `carryOut` keep their previous values for every opCode.
- R10: `aluCarryIn` is combinational. It is 0 when cinMode is 2'b00, 1 when cinMode is 2'b01, and equal to `carryIn` when cinMode is 2'b10 or 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| opEn | input | 1 | Operation enable; the outputs load only when this is high |
| opCode | input | 3 | Operation code (see R2 to R8) |
| accIn | input | 8 | Current accumulator value |
| carryIn | input | 1 | Current carry flag |
| cinMode | input | 2 | Adder carry-in source select (see R10) |
| accOut | output | 8 | Registered accumulator result |
| carryOut | output | 1 | Registered carry result |
| aluCarryIn | output | 1 | Carry-in for the adder |

## Verification
Every operation code is swept over all 256 accumulator values, once with the carry at 0 and once with it at 1. The carry sweep shows whether the old carry is wrongly fed into a plain rotate or an arithmetic shift, or wrongly left out of a rotate through carry. The alternating-bit and sign-bit values show whether the direction or the fill bit is swapped. A second pass toggles the enable in a fixed rhythm while the same codes are applied, so a held result can be told apart from a freshly computed one. The carry-in selector is tried in all four modes with both carry values.

// File: rtl/shiftcarry_pkg.sv
package shiftcarry_pkg;

  typedef enum logic [2:0] {
    OP_RL   = 3'b000,
    OP_RR   = 3'b001,
    OP_RLC  = 3'b010,
    OP_RRC  = 3'b011,
    OP_SAL  = 3'b100,
    OP_SAR  = 3'b101,
    OP_IDLE = 3'b110,
    OP_IDL2 = 3'b111
  } shiftOp_e;

  typedef enum logic [1:0] {
    FILL_WRAP  = 2'b00,
    FILL_CARRY = 2'b01,
    FILL_ZERO  = 2'b10,
    FILL_SIGN  = 2'b11
  } fill_e;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'b00,
    CIN_ONE   = 2'b01,
    CIN_KEEP  = 2'b10,
    CIN_KEEP2 = 2'b11
  } cinMode_e;

  typedef struct packed {
    logic  load;
    logic  goLeft;
    fill_e fillSel;
  } strobes_t;

endpackage

// File: rtl/acc_shift_ctrl.sv
module acc_shift_ctrl
  import shiftcarry_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opEn,
  input  logic [OP_W-1:0] opCode,
  output strobes_t        strb
);

  shiftOp_e opDec;

  assign opDec = shiftOp_e'(opCode);

  always_comb begin
    strb = '{load: 1'b0, goLeft: 1'b0, fillSel: FILL_WRAP};
    unique case (opDec)
      OP_RL:  strb = '{load: opEn, goLeft: 1'b1, fillSel: FILL_WRAP};
      OP_RR:  strb = '{load: opEn, goLeft: 1'b0, fillSel: FILL_WRAP};
      OP_RLC: strb = '{load: opEn, goLeft: 1'b1, fillSel: FILL_CARRY};
      OP_RRC: strb = '{load: opEn, goLeft: 1'b0, fillSel: FILL_CARRY};
      OP_SAL: strb = '{load: opEn, goLeft: 1'b1, fillSel: FILL_ZERO};
      OP_SAR: strb = '{load: opEn, goLeft: 1'b0, fillSel: FILL_SIGN};
      default: strb = '{load: 1'b0, goLeft: 1'b0, fillSel: FILL_WRAP};
    endcase
  end

  // R8: the idle codes never raise the load strobe
  p_idle_no_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opCode[OP_W-1:OP_W-2] == 2'b11) |-> !strb.load);

  // R9: no load strobe without the enable
  p_no_enable_no_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    !opEn |-> !strb.load);

endmodule

// File: rtl/acc_shift_dp.sv
module acc_shift_dp
  import shiftcarry_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  input  logic [1:0]        cinMode,
  output logic [DATA_W-1:0] accQ,
  output logic              carryQ,
  output logic              aluCarryIn
);

  localparam int MSB = DATA_W - 1;

  logic              exitBit;
  logic              fillBit;
  logic [DATA_W-1:0] shifted;

  // exit multiplexer: the end bit that leaves the word
  assign exitBit = strb.goLeft ? accIn[MSB] : accIn[0];

  // fill multiplexer: the bit that enters the vacated end
  always_comb begin
    unique case (strb.fillSel)
      FILL_WRAP:  fillBit = strb.goLeft ? accIn[MSB] : accIn[0];
      FILL_CARRY: fillBit = carryIn;
      FILL_ZERO:  fillBit = 1'b0;
      FILL_SIGN:  fillBit = accIn[MSB];
      default:    fillBit = 1'b0;
    endcase
  end

  assign shifted = strb.goLeft ? {accIn[MSB-1:0], fillBit}
                               : {fillBit, accIn[MSB:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      carryQ <= 1'b0;
    end else if (strb.load) begin
      accQ   <= shifted;
      carryQ <= exitBit;
    end
  end

  // adder carry-in source
  always_comb begin
    unique case (cinMode_e'(cinMode))
      CIN_ZERO: aluCarryIn = 1'b0;
      CIN_ONE:  aluCarryIn = 1'b1;
      default:  aluCarryIn = carryIn;
    endcase
  end

  // R2: a left move puts the old MSB into the carry
  p_left_carry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.goLeft) |=> (carryQ == $past(accIn[MSB])));

  // R3: a right move puts the old LSB into the carry
  p_right_carry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.goLeft) |=> (carryQ == $past(accIn[0])));

  // R4: a left rotate through carry moves the old carry into bit 0
  p_rlc_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.goLeft && strb.fillSel == FILL_CARRY)
      |=> (accQ[0] == $past(carryIn)));

  // R7: an arithmetic right shift keeps the sign bit
  p_sign_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.fillSel == FILL_SIGN) |=> (accQ[MSB] == $past(accIn[MSB])));

  // R9: the state holds without a load
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(accQ) && $stable(carryQ)));

  // R10: a forced carry-in ignores the flag
  p_cin_forced_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cinMode[1] == 1'b0) |-> (aluCarryIn == cinMode[0]));

endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import shiftcarry_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OP_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opEn,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  input  logic [1:0]        cinMode,
  output logic [DATA_W-1:0] accOut,
  output logic              carryOut,
  output logic              aluCarryIn
);

  strobes_t strb;

  acc_shift_ctrl #(.OP_W(OP_W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .opEn  (opEn),
    .opCode(opCode),
    .strb  (strb)
  );

  acc_shift_dp #(.DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .accIn     (accIn),
    .carryIn   (carryIn),
    .cinMode   (cinMode),
    .accQ      (accOut),
    .carryQ    (carryOut),
    .aluCarryIn(aluCarryIn)
  );

  // R1: reset clears both outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (accOut == '0 && carryOut == 1'b0));

endmodule

// File: tb/tb_acc_shift_unit.sv
`timescale 1ns/1ps
module tb_acc_shift_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opEn = 1'b0;
  logic [2:0] opCode = 3'b000;
  logic [7:0] accIn = 8'h00;
  logic       carryIn = 1'b0;
  logic [1:0] cinMode = 2'b00;
  logic [7:0] accOut;
  logic       carryOut;
  logic       aluCarryIn;

  int testsRun = 0;
  int testsFailed = 0;
  int expAcc = 0;
  int expC = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acc_shift_unit dut (
    .clk(clk), .rstN(rstN), .opEn(opEn), .opCode(opCode), .accIn(accIn),
    .carryIn(carryIn), .cinMode(cinMode), .accOut(accOut),
    .carryOut(carryOut), .aluCarryIn(aluCarryIn)
  );

  function automatic string tagFor(int op, bit en);
    if (!en) return "R9";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // arithmetic model of one step; updates expAcc / expC
  task automatic model(bit en, int op, int a, int c);
    if (!en || op >= 6) return;
    case (op)
      0: begin expAcc = ((a * 2) % 256) + (a / 128); expC = a / 128; end
      1: begin expAcc = (a / 2) + (a % 2) * 128; expC = a % 2; end
      2: begin expAcc = ((a * 2) % 256) + c; expC = a / 128; end
      3: begin expAcc = (a / 2) + c * 128; expC = a % 2; end
      4: begin expAcc = (a * 2) % 256; expC = a / 128; end
      default: begin expAcc = (a / 2) + (a / 128) * 128; expC = a % 2; end
    endcase
  endtask

  task automatic step(bit en, int op, int a, int c);
    @(negedge clk);
    opEn = en; opCode = op[2:0]; accIn = a[7:0]; carryIn = c[0];
    @(posedge clk);
    #1;
    model(en, op, a, c);
    check(tagFor(op, en), int'(accOut), expAcc, "accOut");
    check(tagFor(op, en), int'(carryOut), expC, "carryOut");
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs at zero even with an active operation
    opEn = 1'b1; opCode = 3'b000; accIn = 8'hFF; carryIn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(accOut), 0, "accOut in reset");
    check("R1", int'(carryOut), 0, "carryOut in reset");
    @(negedge clk);
    rstN = 1'b1; opEn = 1'b0;
    @(posedge clk); #1;
    check("R1", int'(accOut), 0, "accOut after reset");

    // exhaustive sweep R2..R8 with enable high, both carry values
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          step(1'b1, op, a, c);

    // R9: enable toggled in a fixed rhythm over all codes
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a += 3)
        step((a % 2) == 0, op, a, (a / 3) % 2);

    // R8: idle code right after a known result keeps it
    step(1'b1, 0, 8'h81, 0);
    step(1'b1, 6, 8'h00, 1);
    step(1'b1, 7, 8'h55, 0);

    // R10: carry-in selector, all modes, both carries
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++) begin
        @(negedge clk);
        cinMode = m[1:0]; carryIn = c[0];
        #1;
        check("R10", int'(aluCarryIn), (m == 0) ? 0 : (m == 1) ? 1 : c, "aluCarryIn");
      end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule